// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block sits on the request side of a core port and expands one burst descriptor into a stream of per-beat addresses. A burst is accepted with a valid/ready handshake. The descriptor carries a start byte address, a length in words, a sequence selector, a flag for precise versus imprecise length, and a flag for single-request/multiple-data operation. From the next cycle on, the block presents one address per beat on a second valid/ready handshake. Each beat carries a last-beat marker and a command marker.

Four address sequences are supported. Incrementing steps by one word per beat. Wrapping walks upward inside an aligned block and wraps back to its base. Streaming repeats the start address on every beat. XOR visits the words of an aligned block in the order start-index XOR beat-number. In a precise burst the generator counts the beats itself. In an imprecise burst the end is taken from a remaining-length input that the requester updates on every beat. The command marker shows which beats carry a request phase: only the first beat in single-request mode, and every beat otherwise.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is held and after it is released, `req_ready` is 1 and `beat_valid` is 0.
- R2: A descriptor taken on a `req_valid`/`req_ready` edge makes `beat_valid` 1 and `req_ready` 0 from the next cycle, and the first beat's address equals the start address.
- R3: Sequence code 2'b00 (incrementing): beat n has address start + n × 4 bytes (word size 4 bytes).
- R4: Sequence code 2'b01 (wrapping, length a power of two): the word index of beat n is the base of the aligned block of `req_len` words that holds the start word, plus ((start word offset in that block + n) mod `req_len`). The start's low two byte bits are kept.
- R5: Sequence code 2'b10 (streaming): every beat has the start address.
- R6: Sequence code 2'b11 (XOR): the word index of beat n is the block base plus (start word offset XOR n), with the block defined as in R4.
- R7: With `req_precise` = 1, `beat_last` is 1 exactly on beat `req_len` − 1 (counting from 0), and `len_now` has no effect.
- R8: With `req_precise` = 0, `beat_last` is 1 exactly on the beat during which `len_now` reads 1. For wrapping and XOR, the block size is still taken from `req_len`.
- R9: With `req_srmd` = 1, `beat_cmd` is 1 on the first beat only. With `req_srmd` = 0, it is 1 on every beat.
- R10: While `beat_valid` is 1 and `beat_ready` is 0, `beat_addr` holds its value. `req_ready` returns to 1 in the cycle after the last beat is consumed.
- R11: While a burst is in progress, `req_ready` is 0, and a `req_valid` with new fields does not change the beats of the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Burst descriptor offered |
| req_ready | output | 1 | Generator idle, descriptor can be taken |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Burst length in words (block size for wrap/XOR) |
| req_seq | input | 2 | Sequence: 00 incr, 01 wrap, 10 stream, 11 XOR |
| req_precise | input | 1 | 1 = length known up front |
| req_srmd | input | 1 | 1 = single request, multiple data |
| len_now | input | LEN_W | Remaining beats including this one (imprecise bursts) |
| beat_valid | output | 1 | A beat address is presented |
| beat_ready | input | 1 | The beat is consumed |
| beat_addr | output | ADDR_W | Byte address of the current beat |
| beat_last | output | 1 | Current beat ends the burst |
| beat_cmd | output | 1 | Current beat carries a request phase |

## Verification
The hardest case to reach from the ports is an imprecise wrapping burst that runs longer than its block. Here the address must wrap more than once while the end is decided only by the per-beat length input. The stimulus reaches it by declaring a block of four words and then counting `len_now` down from six. A further case is a stall on odd beats during which a conflicting descriptor is held on the request inputs. This shows both that the address is held under backpressure and that the running burst is not disturbed.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 8,
  parameter int BYTE_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [1:0]        req_seq,
  input  logic              req_precise,
  input  logic              req_srmd,
  input  logic [LEN_W-1:0]  len_now,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              beat_last,
  output logic              beat_cmd
);
  localparam int WW = ADDR_W - BYTE_BITS;

  logic              busy;
  logic [LEN_W-1:0]  n_q, len_q;
  logic [ADDR_W-1:0] start_q;
  logic [1:0]        seq_q;
  logic              precise_q, srmd_q;

  logic [WW-1:0] w0, nx, mask, blk, word;

  assign w0   = start_q[ADDR_W-1:BYTE_BITS];
  assign nx   = WW'(n_q);
  assign mask = WW'(len_q) - WW'(1);
  assign blk  = w0 & ~mask;

  always_comb begin
    case (seq_q)
      2'b00:   word = w0 + nx;
      2'b01:   word = blk | ((w0 + nx) & mask);
      2'b10:   word = w0;
      default: word = blk | ((w0 ^ nx) & mask);
    endcase
  end

  assign req_ready  = !busy;
  assign beat_valid = busy;
  assign beat_addr  = {word, start_q[BYTE_BITS-1:0]};
  assign beat_last  = precise_q ? (n_q == len_q - LEN_W'(1)) : (len_now == LEN_W'(1));
  assign beat_cmd   = !srmd_q || (n_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      n_q       <= '0;
      len_q     <= '0;
      start_q   <= '0;
      seq_q     <= 2'b00;
      precise_q <= 1'b0;
      srmd_q    <= 1'b0;
    end else if (req_valid && req_ready) begin
      busy      <= 1'b1;
      n_q       <= '0;
      len_q     <= req_len;
      start_q   <= req_addr;
      seq_q     <= req_seq;
      precise_q <= req_precise;
      srmd_q    <= req_srmd;
    end else if (beat_valid && beat_ready) begin
      if (beat_last) busy <= 1'b0;
      else           n_q  <= n_q + LEN_W'(1);
    end
  end
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_srmd,
  input logic              beat_valid,
  input logic              beat_ready,
  input logic [ADDR_W-1:0] beat_addr,
  input logic              beat_last,
  input logic              beat_cmd
);
  logic srmd_seen;
  always_ff @(posedge clk) begin
    if (!rst_n) srmd_seen <= 1'b0;
    else if (req_valid && req_ready) srmd_seen <= req_srmd;
  end

  a_r2_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (beat_valid && !req_ready));

  a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_addr) && $stable(beat_cmd)));

  a_r10_ready_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready && beat_last) |=> req_ready);

  a_r11_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> !req_ready);

  a_r9_single_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready && !beat_last && srmd_seen) |=> !beat_cmd);
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_srmd(req_srmd), .beat_valid(beat_valid), .beat_ready(beat_ready),
  .beat_addr(beat_addr), .beat_last(beat_last), .beat_cmd(beat_cmd)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [7:0]  req_len = '0;
  logic [1:0]  req_seq = '0;
  logic        req_precise = 1'b0;
  logic        req_srmd = 1'b0;
  logic [7:0]  len_now = 8'd1;
  logic        beat_valid;
  logic        beat_ready = 1'b0;
  logic [31:0] beat_addr;
  logic        beat_last;
  logic        beat_cmd;

  int checks = 0;
  int fails  = 0;
  logic [33:0] exp_q[$];

  always #4 clk = ~clk;

  burst_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_seq(req_seq),
    .req_precise(req_precise), .req_srmd(req_srmd), .len_now(len_now),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_addr(beat_addr),
    .beat_last(beat_last), .beat_cmd(beat_cmd)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_addr(input logic [31:0] a, input int len,
                                           input logic [1:0] sq, input int n);
    logic [31:0] w, base, off;
    w    = a >> 2;
    base = (w / len) * len;
    off  = w % len;
    case (sq)
      2'b00:   w = w + n;
      2'b01:   w = base + ((off + n) % len);
      2'b10:   w = w;
      default: w = base + (off ^ n);
    endcase
    return (w << 2) | (a & 32'h3);
  endfunction

  task automatic run_burst(input logic [31:0] a, input logic [7:0] rl, input logic [1:0] sq,
                           input bit pr, input bit sm, input int total, input bit junk);
    bit ok;
    logic [31:0] ea;
    @(posedge clk); #1;
    req_addr = a; req_len = rl; req_seq = sq; req_precise = pr; req_srmd = sm;
    req_valid = 1'b1;
    forever begin
      @(negedge clk); ok = req_ready;
      @(posedge clk); #1;
      if (ok) break;
    end
    if (junk) begin
      req_addr = 32'hDEAD_0000; req_len = 8'd3; req_seq = 2'b11;
      req_precise = ~pr; req_srmd = ~sm;
    end else req_valid = 1'b0;
    for (int k = 0; k < total; k++) begin
      ea = ref_addr(a, int'(rl), sq, k);
      exp_q.push_back({ea, (k == total - 1), (!sm || k == 0)});
      len_now = pr ? 8'd1 : 8'(total - k);
      if (k % 2 == 1) begin
        beat_ready = 1'b0;
        @(negedge clk);
        chk(beat_valid && beat_addr == ea, "R10 hold under stall", beat_addr, ea);
        chk(!req_ready, "R11 busy blocks request", req_ready, 0);
        @(posedge clk); #1;
      end
      beat_ready = 1'b1;
      @(posedge clk); #1;
      beat_ready = 1'b0;
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk(req_ready && !beat_valid, "R10 ready after last", {req_ready, beat_valid}, 2'b10);
  endtask

  always @(negedge clk) begin
    if (rst_n && beat_valid && beat_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected beat", beat_addr, 0);
      end else begin
        logic [33:0] e;
        e = exp_q.pop_front();
        // R2-R9: address, last and command of each consumed beat
        chk({beat_addr, beat_last, beat_cmd} == e, "R3 R4 R5 R6 R7 R8 R9 beat",
            {beat_addr, beat_last, beat_cmd}, e);
      end
    end
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        chk(1'b0, "watchdog", cyc, 20000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready && !beat_valid, "R1 reset state", {req_ready, beat_valid}, 2'b10);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !beat_valid, "R1 idle after reset", {req_ready, beat_valid}, 2'b10);
    // R3 incrementing, R7 precise, R11 junk request held during burst
    run_burst(32'h0000_0100, 8'd5, 2'b00, 1'b1, 1'b0, 5, 1'b1);
    // R4 wrapping from middle of block
    run_burst(32'h0000_0208, 8'd4, 2'b01, 1'b1, 1'b0, 4, 1'b0);
    // R5 streaming with byte offset, R9 single request
    run_burst(32'h0000_1233, 8'd3, 2'b10, 1'b1, 1'b1, 3, 1'b0);
    // R6 XOR order
    run_burst(32'h0000_0414, 8'd8, 2'b11, 1'b1, 1'b0, 8, 1'b0);
    // R8 imprecise incrementing, req_len differs from actual length
    run_burst(32'h0000_0040, 8'd2, 2'b00, 1'b0, 1'b1, 6, 1'b0);
    // R8 imprecise wrapping past the block twice
    run_burst(32'h0000_030C, 8'd4, 2'b01, 1'b0, 1'b0, 6, 1'b0);
    // R7 single-beat burst
    run_burst(32'h0000_0800, 8'd1, 2'b00, 1'b1, 1'b1, 1, 1'b0);
    // R10 back-to-back XOR after a burst
    run_burst(32'h0000_0FF8, 8'd2, 2'b11, 1'b1, 1'b0, 2, 1'b0);
    repeat (3) @(posedge clk);
    chk(exp_q.size() == 0, "R2 all beats seen", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule